// File: doc/BRIEF.md
# Four-Lane Exponent Maximum and Alignment Shift Selector

This block sits in front of the mantissa alignment stage of a four-term dot-product unit. It receives the four product exponents, one per lane. It reports the largest of them as the result exponent, flags which lane holds it with a one-hot vector, and gives every lane the right-shift distance that lines its mantissa up with the largest one.

All six pairwise exponent differences are formed side by side. The winning lane is decided from the sign bits of those differences alone. Each lane then reuses one of the precomputed differences as its shift distance, or zero if it is the winner, so no second subtraction against the maximum is needed. A difference that comes out negative because of how its pair is oriented is negated, so every distance is a non-negative right shift. Distances are capped at the mantissa datapath width. The outputs sit behind one register stage, with a valid flag travelling alongside them.

Top module: `exp_align_sel`

## Requirements
- R1: One cycle after a cycle with `valid_i` high, `max_exp_o` equals the largest of the four exponents presented in that cycle.
- R2: One cycle after `valid_i` is high, `win_o` has exactly one bit set. Bit k marks lane k as holding the largest exponent. When lanes tie, the lowest-numbered tied lane is marked.
- R3: The shift amount of the lane marked in `win_o` is zero.
- R4: For every other lane k, the shift amount equals the largest exponent minus exponent k whenever that difference is below `SHIFT_MAX` (default 24).
- R5: A lane whose exponent gap is `SHIFT_MAX` or more receives exactly `SHIFT_MAX`. No shift amount ever exceeds `SHIFT_MAX`.
- R6: `valid_o` equals `valid_i` delayed by one cycle. While `rst_ni` is low, `valid_o`, `max_exp_o`, `win_o` and `shift_o` are all zero.
- R7: In a cycle with `valid_i` low, the exponent inputs are ignored, and `max_exp_o`, `win_o` and `shift_o` keep their previous values.
- R8: Lane k's exponent occupies `exp_i[k*EXP_W +: EXP_W]`, and its shift amount occupies `shift_o[k*SH_W +: SH_W]`. Here `EXP_W` defaults to 9 and `SH_W` is the width needed to hold `SHIFT_MAX` (5 by default). Exponents are unsigned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Exponent inputs are valid this cycle |
| exp_i | input | 4*EXP_W | Four unsigned lane exponents, lane 0 in the low bits |
| valid_o | output | 1 | Registered outputs hold a new result |
| max_exp_o | output | EXP_W | Largest exponent |
| win_o | output | 4 | One-hot mark of the lane holding the largest exponent |
| shift_o | output | 4*SH_W | Per-lane right-shift amounts, lane 0 in the low bits |

## Verification
The bench places the maximum in each lane in turn. This catches a winner decode that reads a difference sign with the wrong polarity, which would mark a smaller lane or no lane at all. Ties between two, three and four lanes expose a design that treats a zero difference as a loss for the earlier lane: it would mark several lanes or none, and hand a tied lane a stray distance. Gaps just below, exactly at and above the cap test saturation, where a design without a clamp would wrap the 5-bit amount. Winners placed after the lane being shifted exercise the negation path, which shows up as huge or wrapped distances if the sign correction is lost. A cycle with valid low and changed inputs shows whether the register stage wrongly updates when it should hold.

// File: rtl/exp_align_pkg.sv
package exp_align_pkg;
  localparam int NLANE = 4;
  localparam int NPAIR = NLANE * (NLANE - 1) / 2;

  // index of ordered pair (a,b), a<b: 01,02,03,12,13,23 -> 0..5
  function automatic int pair_idx(input int a, input int b);
    return a * (2 * NLANE - 1 - a) / 2 + (b - a - 1);
  endfunction
endpackage

// File: rtl/exp_pair_diff.sv
module exp_pair_diff
  import exp_align_pkg::*;
#(
  parameter int EXP_W = 9,
  localparam int DW = EXP_W + 1
) (
  input  logic [NLANE*EXP_W-1:0] exp_i,
  output logic [NPAIR*DW-1:0]    diff_o
);
  for (genvar a = 0; a < NLANE; a++) begin : g_a
    for (genvar b = a + 1; b < NLANE; b++) begin : g_b
      localparam int P = pair_idx(a, b);
      assign diff_o[P*DW +: DW] = {1'b0, exp_i[a*EXP_W +: EXP_W]}
                                - {1'b0, exp_i[b*EXP_W +: EXP_W]};
    end
  end
endmodule

// File: rtl/exp_max_decide.sv
module exp_max_decide
  import exp_align_pkg::*;
#(
  parameter int EXP_W = 9,
  localparam int DW = EXP_W + 1
) (
  input  logic [NPAIR*DW-1:0] diff_i,
  output logic [NLANE-1:0]    win_o
);
  logic [NPAIR-1:0] neg;

  for (genvar p = 0; p < NPAIR; p++) begin : g_sgn
    assign neg[p] = diff_i[p*DW + DW - 1];
  end

  // lane k wins: strictly above every earlier lane, not below any later one
  always_comb begin
    for (int k = 0; k < NLANE; k++) begin
      win_o[k] = 1'b1;
      for (int j = 0; j < NLANE; j++) begin
        if (j < k)      win_o[k] = win_o[k] & neg[pair_idx(j, k)];
        else if (j > k) win_o[k] = win_o[k] & ~neg[pair_idx(k, j)];
      end
    end
  end
endmodule

// File: rtl/exp_lane_shift.sv
module exp_lane_shift
  import exp_align_pkg::*;
#(
  parameter int EXP_W     = 9,
  parameter int SHIFT_MAX = 24,
  parameter int LANE      = 0,
  localparam int DW   = EXP_W + 1,
  localparam int SH_W = $clog2(SHIFT_MAX + 1)
) (
  input  logic [NPAIR*DW-1:0] diff_i,
  input  logic [NLANE-1:0]    win_i,
  output logic [SH_W-1:0]     shift_o
);
  logic [DW-1:0] sel;

  always_comb begin
    sel = '0;
    for (int w = 0; w < NLANE; w++) begin
      if (win_i[w] && w < LANE)
        sel = diff_i[pair_idx(w, LANE)*DW +: DW];
      else if (win_i[w] && w > LANE)
        sel = ~diff_i[pair_idx(LANE, w)*DW +: DW] + 1'b1; // orientation fix
    end
  end

  assign shift_o = (sel >= DW'(SHIFT_MAX)) ? SH_W'(SHIFT_MAX) : sel[SH_W-1:0];
endmodule

// File: rtl/exp_align_sel.sv
module exp_align_sel
  import exp_align_pkg::*;
#(
  parameter int EXP_W     = 9,
  parameter int SHIFT_MAX = 24,
  localparam int DW   = EXP_W + 1,
  localparam int SH_W = $clog2(SHIFT_MAX + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic [NLANE*EXP_W-1:0] exp_i,
  output logic                   valid_o,
  output logic [EXP_W-1:0]       max_exp_o,
  output logic [NLANE-1:0]       win_o,
  output logic [NLANE*SH_W-1:0]  shift_o
);
  logic [NPAIR*DW-1:0]   diff;
  logic [NLANE-1:0]      win;
  logic [NLANE*SH_W-1:0] shift;
  logic [EXP_W-1:0]      max_exp;

  exp_pair_diff #(.EXP_W(EXP_W)) u_diff (
    .exp_i  (exp_i),
    .diff_o (diff)
  );

  exp_max_decide #(.EXP_W(EXP_W)) u_decide (
    .diff_i (diff),
    .win_o  (win)
  );

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    exp_lane_shift #(.EXP_W(EXP_W), .SHIFT_MAX(SHIFT_MAX), .LANE(k)) u_shift (
      .diff_i  (diff),
      .win_i   (win),
      .shift_o (shift[k*SH_W +: SH_W])
    );
  end

  always_comb begin
    max_exp = '0;
    for (int k = 0; k < NLANE; k++)
      if (win[k]) max_exp = exp_i[k*EXP_W +: EXP_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      max_exp_o <= '0;
      win_o     <= '0;
      shift_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        max_exp_o <= max_exp;
        win_o     <= win;
        shift_o   <= shift;
      end
    end
  end
endmodule

// File: rtl/exp_align_sel_chk.sv
module exp_align_sel_chk #(
  parameter int EXP_W     = 9,
  parameter int SHIFT_MAX = 24,
  parameter int SH_W      = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic               valid_o,
  input logic [EXP_W-1:0]   max_exp_o,
  input logic [3:0]         win_o,
  input logic [4*SH_W-1:0]  shift_o
);
  assert_valid_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_one_winner_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $countones(win_o) == 1);
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(max_exp_o) && $stable(win_o) && $stable(shift_o)));

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assert_win_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && win_o[k]) |-> shift_o[k*SH_W +: SH_W] == '0);
    assert_shift_cap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shift_o[k*SH_W +: SH_W] <= SH_W'(SHIFT_MAX));
  end
endmodule

bind exp_align_sel exp_align_sel_chk #(
  .EXP_W(EXP_W), .SHIFT_MAX(SHIFT_MAX), .SH_W(SH_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .valid_o(valid_o),
  .max_exp_o(max_exp_o), .win_o(win_o), .shift_o(shift_o)
);

// File: tb/exp_align_sel_bench.sv
`timescale 1ns/1ps
module exp_align_sel_bench;
  localparam int EW = 9;
  localparam int SM = 24;
  localparam int SW = 5;
  localparam int NV = 8;

  // {e3,e2,e1,e0}, expected max, expected winner lane
  localparam logic [4*EW-1:0] VEC_E [NV] = '{
    {9'd70,  9'd80,  9'd90,  9'd100},
    {9'd100, 9'd90,  9'd80,  9'd70},
    {9'd50,  9'd50,  9'd50,  9'd50},
    {9'd5,   9'd200, 9'd200, 9'd10},
    {9'd310, 9'd299, 9'd301, 9'd300},
    {9'd487, 9'd511, 9'd0,   9'd511},
    {9'd1,   9'd0,   9'd0,   9'd0},
    {9'd143, 9'd120, 9'd143, 9'd120}
  };
  localparam int VEC_MAX [NV] = '{100, 100, 50, 200, 310, 511, 1, 143};
  localparam int VEC_WIN [NV] = '{0, 3, 0, 1, 3, 0, 3, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0;
  logic [4*EW-1:0] exp_i = '0;
  logic valid_o;
  logic [EW-1:0] max_exp_o;
  logic [3:0] win_o;
  logic [4*SW-1:0] shift_o;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  exp_align_sel u_exp_align_sel (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .exp_i(exp_i),
    .valid_o(valid_o), .max_exp_o(max_exp_o), .win_o(win_o), .shift_o(shift_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic [4*EW-1:0] e);
    @(negedge clk);
    valid_i = v;
    exp_i = e;
    @(posedge clk);
    #1;
  endtask

  task automatic check_vec(input logic [4*EW-1:0] e, input int mx, input int w);
    chk("R6 valid_o", int'(valid_o), 1);
    chk("R1 max_exp", int'(max_exp_o), mx);
    chk("R2 winner", int'(win_o), 1 << w);
    for (int k = 0; k < 4; k++) begin
      int gap = mx - int'(e[k*EW +: EW]);
      int exp_sh = (gap >= SM) ? SM : gap;
      if (k == w) chk("R3 winner shift", int'(shift_o[k*SW +: SW]), 0);
      else if (gap >= SM) chk("R5 saturated shift", int'(shift_o[k*SW +: SW]), exp_sh);
      else chk("R4 R8 lane shift", int'(shift_o[k*SW +: SW]), exp_sh);
    end
  endtask

  initial begin
    #1;
    chk("R6 reset valid_o", int'(valid_o), 0);
    chk("R6 reset max_exp", int'(max_exp_o), 0);
    chk("R6 reset win", int'(win_o), 0);
    chk("R6 reset shift", int'(shift_o), 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // back-to-back table walk
    for (int i = 0; i < NV; i++) begin
      apply(1'b1, VEC_E[i]);
      check_vec(VEC_E[i], VEC_MAX[i], VEC_WIN[i]);
    end

    // R7: invalid cycle with new exponents must not disturb outputs
    apply(1'b0, {9'd400, 9'd1, 9'd2, 9'd3});
    chk("R6 valid drop", int'(valid_o), 0);
    check_hold: begin
      chk("R7 hold max", int'(max_exp_o), 143);
      chk("R7 hold win", int'(win_o), 4'b0010);
      chk("R7 hold shift lane0", int'(shift_o[0 +: SW]), 23);
    end

    // gap exactly SM-1 and large gap with winner in lane 2
    apply(1'b1, {9'd0, 9'd300, 9'd277, 9'd276});
    check_vec({9'd0, 9'd300, 9'd277, 9'd276}, 300, 2);

    // reset mid-stream clears outputs
    @(negedge clk) rst_n = 1'b0;
    #1;
    chk("R6 async reset valid", int'(valid_o), 0);
    chk("R6 async reset win", int'(win_o), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #50000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule